// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the sync and enable strobes of a parallel RGB panel from the pixel clock, and reports the coordinate of the pixel being shown. A write port loads a staged set of timing values: for each axis these are the sync pulse width, back porch, active extent and front porch. It also loads a frame buffer base address, four polarity controls, an interrupt enable and the run request. The counters never use the staged set directly. They run from an active copy, which is refreshed only when the run starts or at a frame boundary after a load request.

Stopping is graceful. When software drops the run request, the current frame completes and the status output then goes low. A sticky vertical-blank flag marks the entry into vertical front porch. A held soft reset puts the counters and the active copy back to zero.

Top module: `disp_timing_gen`

## Requirements
- R1: Each line runs through sync, back porch, active and front porch in that order, and lasts the sum of the four horizontal fields. HSYNC is asserted (before polarity) for the first sync-width clocks of every line.
- R2: The line counter advances once per completed line, and each frame lasts the sum of the four vertical fields in lines. VSYNC is asserted (before polarity) on the first sync-width lines and changes only at line boundaries.
- R3: Data enable is asserted only when both axes are in their active regions. There, `pix_x`/`pix_y` count from 0 at the first active clock and the first active line. Both coordinates read 0 whenever data enable is low.
- R4: Control register (address 0) bits 2, 3, 4 and 5 invert HSYNC, VSYNC, data enable and select falling-edge data drive (`drive_on_fall`). They act from the cycle after the write. While stopped, each strobe sits at its inactive level.
- R5: Writes to the timing registers (addresses 1–4: low half active/back porch, high half front porch/sync width, per axis) and the frame address (address 5) do not change the output timing or `fb_addr` of a running frame. They take effect at the next frame boundary after a load request (control bit 1 written 1).
- R6: The load request clears itself once it has been served, so staged writes made after a load wait for another request.
- R7: Writing control bit 0 as 0 leaves `en_status` high until the current frame's last pixel clock. The following cycle `en_status` is low and all outputs are idle.
- R8: `vblank_flag` is set on the clock that moves the frame from its last active line into vertical front porch. Writing 1 to bit 0 of address 7 clears it, and a set in the same cycle wins. `vblank_irq` is the flag gated by bit 0 of address 6.
- R9: While `soft_rst` is high, the counters, the active timing set, `fb_addr`, the load request, the flag and `en_status` are held at zero. The staged registers and control bits are kept.
- R10: When the run bit is set and the block is stopped, the next clock starts the frame with the staged values copied straight into the active set, including `fb_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Held soft reset of counters and active set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| drive_on_fall | output | 1 | Selects the falling pixel clock edge for data |
| pix_x | output | 12 | Column inside the active area |
| pix_y | output | 12 | Row inside the active area |
| en_status | output | 1 | Raster is running |
| vblank_flag | output | 1 | Sticky vertical-blank status |
| vblank_irq | output | 1 | Flag gated by its enable |
| fb_addr | output | 32 | Active frame buffer address |

## Verification
The assertions take every timing field to be at least 1, so each phase lasts at least one count and a vertical-blank start always exists. They also take inputs to be stable around the rising edge. The stimulus only ever writes nonzero fields, and it changes inputs on the falling edge. It does this across polarity changes, mid-run staged writes, stops and a soft reset during a running frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CFG_W  = 12;
  localparam int TW     = CFG_W + 2;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [CFG_W-1:0] sw;
    logic [CFG_W-1:0] bp;
    logic [CFG_W-1:0] act;
    logic [CFG_W-1:0] fp;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
  } tim_cfg_t;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0, RA_HLO = 3'd1, RA_HHI = 3'd2, RA_VLO = 3'd3,
    RA_VHI = 3'd4, RA_FBAD = 3'd5, RA_IREN = 3'd6, RA_STAT = 3'd7
  } reg_addr_e;

  function automatic logic [TW-1:0] axis_total(axis_cfg_t c);
    return TW'(c.sw) + TW'(c.bp) + TW'(c.act) + TW'(c.fp);
  endfunction

  function automatic logic [TW-1:0] axis_act_start(axis_cfg_t c);
    return TW'(c.sw) + TW'(c.bp);
  endfunction
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  axis_cfg_t        cfg,
  output logic [TW-1:0]    cnt,
  output logic             sync_on,
  output logic             in_act,
  output logic             last,
  output logic             act_last,
  output logic [CFG_W-1:0] pos
);
  logic [TW-1:0] total, a_start, a_end;

  assign total   = axis_total(cfg);
  assign a_start = axis_act_start(cfg);
  assign a_end   = a_start + TW'(cfg.act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= last ? '0 : cnt + 1'b1;
  end

  assign last     = (cnt == total - 1'b1);
  assign sync_on  = (cnt < TW'(cfg.sw));
  assign in_act   = (cnt >= a_start) && (cnt < a_end);
  assign act_last = (cnt == a_end - 1'b1);
  assign pos      = in_act ? CFG_W'(cnt - a_start) : '0;
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int FB_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output tim_cfg_t          stg,
  output logic [FB_W-1:0]   stg_fb,
  output logic              ctrl_en,
  output logic [3:0]        inv,
  output logic              irq_en,
  output logic              req_wr,
  output logic              clr_wr
);
  logic [CFG_W-1:0] lo_f, hi_f;

  assign lo_f   = wr_data[CFG_W-1:0];
  assign hi_f   = wr_data[16 +: CFG_W];
  assign req_wr = wr_en && (wr_addr == RA_CTRL) && wr_data[1];
  assign clr_wr = wr_en && (wr_addr == RA_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg     <= '0;
      stg_fb  <= '0;
      ctrl_en <= 1'b0;
      inv     <= '0;
      irq_en  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL: begin
          ctrl_en <= wr_data[0];
          inv     <= wr_data[5:2];
        end
        RA_HLO:  begin stg.h.act <= lo_f; stg.h.bp <= hi_f; end
        RA_HHI:  begin stg.h.fp  <= lo_f; stg.h.sw <= hi_f; end
        RA_VLO:  begin stg.v.act <= lo_f; stg.v.bp <= hi_f; end
        RA_VHI:  begin stg.v.fp  <= lo_f; stg.v.sw <= hi_f; end
        RA_FBAD: stg_fb <= wr_data[FB_W-1:0];
        RA_IREN: irq_en <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int FB_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              drive_on_fall,
  output logic [CFG_W-1:0]  pix_x,
  output logic [CFG_W-1:0]  pix_y,
  output logic              en_status,
  output logic              vblank_flag,
  output logic              vblank_irq,
  output logic [FB_W-1:0]   fb_addr
);
  tim_cfg_t         stg_cfg, act_cfg;
  logic [FB_W-1:0]  stg_fb;
  logic             ctrl_en, irq_en, req_set, clr_wr;
  logic [3:0]       inv;
  logic             running, shadow_req, stat;
  logic [TW-1:0]    h_cnt, v_cnt;
  logic             h_sync, h_act, h_last, h_act_last;
  logic             v_sync, v_act, v_last, v_act_last;
  logic [CFG_W-1:0] h_pos, v_pos;
  logic             cnt_clr, v_adv;
  logic             frame_end, start_evt, vblank_evt, load_evt;
  logic             hs_raw, vs_raw, de_raw;

  dtg_regs #(.FB_W(FB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg(stg_cfg), .stg_fb(stg_fb), .ctrl_en(ctrl_en),
    .inv(inv), .irq_en(irq_en), .req_wr(req_set), .clr_wr(clr_wr)
  );

  assign cnt_clr = soft_rst || !running;
  assign v_adv   = running && h_last;

  dtg_axis u_hax (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(running), .cfg(act_cfg.h),
    .cnt(h_cnt), .sync_on(h_sync), .in_act(h_act), .last(h_last),
    .act_last(h_act_last), .pos(h_pos)
  );

  dtg_axis u_vax (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(v_adv), .cfg(act_cfg.v),
    .cnt(v_cnt), .sync_on(v_sync), .in_act(v_act), .last(v_last),
    .act_last(v_act_last), .pos(v_pos)
  );

  // Named events for the checker
  assign frame_end  = running && h_last && v_last;
  assign start_evt  = ctrl_en && !running && !soft_rst;
  assign vblank_evt = running && h_last && v_act_last;
  assign load_evt   = start_evt || (frame_end && shadow_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      shadow_req <= 1'b0;
      stat       <= 1'b0;
      act_cfg    <= '0;
      fb_addr    <= '0;
    end else if (soft_rst) begin
      running    <= 1'b0;
      shadow_req <= 1'b0;
      stat       <= 1'b0;
      act_cfg    <= '0;
      fb_addr    <= '0;
    end else begin
      if (start_evt)                  running <= 1'b1;
      else if (frame_end && !ctrl_en) running <= 1'b0;

      if (req_set)                     shadow_req <= 1'b1;
      else if (start_evt || frame_end) shadow_req <= 1'b0;

      if (vblank_evt)  stat <= 1'b1;
      else if (clr_wr) stat <= 1'b0;

      if (load_evt) begin
        act_cfg <= stg_cfg;
        fb_addr <= stg_fb;
      end
    end
  end

  assign hs_raw = running && h_sync;
  assign vs_raw = running && v_sync;
  assign de_raw = running && h_act && v_act;

  assign hsync         = hs_raw ^ inv[0];
  assign vsync         = vs_raw ^ inv[1];
  assign de            = de_raw ^ inv[2];
  assign drive_on_fall = inv[3];
  assign pix_x         = de_raw ? h_pos : '0;
  assign pix_y         = de_raw ? v_pos : '0;
  assign en_status     = running;
  assign vblank_flag   = stat;
  assign vblank_irq    = stat && irq_en;
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          hs_raw,
  input logic          vs_raw,
  input logic          de_raw,
  input logic          running,
  input logic          h_last,
  input logic          frame_end,
  input logic          start_evt,
  input logic          vblank_evt,
  input logic          shadow_req,
  input logic          req_set,
  input logic          stat,
  input logic          irq,
  input logic [TW-1:0] h_cnt,
  input logic [TW-1:0] v_cnt,
  input tim_cfg_t      act_cfg,
  input tim_cfg_t      stg_cfg
);
  p_de_sync_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !hs_raw);

  p_vs_line_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !h_last && !soft_rst) |=> $stable(vs_raw));

  p_de_outside_vsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> !vs_raw);

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !start_evt && !soft_rst) |=> $stable(act_cfg));

  p_req_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !req_set) |=> !shadow_req);

  p_stop_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end && !soft_rst) |=> running);

  p_vblank_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_evt && !soft_rst) |=> stat);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat);

  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!running && h_cnt == '0 && v_cnt == '0 && !stat));

  p_start_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (running && act_cfg == $past(stg_cfg)));
endmodule

bind disp_timing_gen dtg_checker u_dtg_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hs_raw(hs_raw),
  .vs_raw(vs_raw), .de_raw(de_raw), .running(running), .h_last(h_last),
  .frame_end(frame_end), .start_evt(start_evt), .vblank_evt(vblank_evt),
  .shadow_req(shadow_req), .req_set(req_set), .stat(stat),
  .irq(vblank_irq), .h_cnt(h_cnt), .v_cnt(v_cnt), .act_cfg(act_cfg),
  .stg_cfg(stg_cfg)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, drive_on_fall, en_status, vblank_flag, vblank_irq;
  logic [11:0] pix_x, pix_y;
  logic [31:0] fb_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state: index 0 sync, 1 back porch, 2 active, 3 front porch
  int s_h[4], s_v[4], a_h[4], a_v[4];
  int s_fb, a_fb, c_en, irqen, run, req, stat, hc, vc;
  bit c_inv[4];

  disp_timing_gen u_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync),
    .de(de), .drive_on_fall(drive_on_fall), .pix_x(pix_x), .pix_y(pix_y),
    .en_status(en_status), .vblank_flag(vblank_flag),
    .vblank_irq(vblank_irq), .fb_addr(fb_addr)
  );

  always #5 clk = ~clk;

  task automatic check(string req_tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic int sum4(int a[4]);
    return a[0] + a[1] + a[2] + a[3];
  endfunction

  task automatic model_step();
    int  htot, vtot, va;
    bit  hl, vl, fe, vbev, st, ld, wctl, wclr;
    htot = sum4(a_h);
    vtot = sum4(a_v);
    va   = a_v[0] + a_v[1];
    hl   = (hc == htot - 1);
    vl   = (vc == vtot - 1);
    fe   = run != 0 && hl && vl;
    vbev = run != 0 && hl && (vc == va + a_v[2] - 1);
    st   = c_en != 0 && run == 0 && !soft_rst;
    wctl = wr_en && wr_addr == 3'd0;
    wclr = wr_en && wr_addr == 3'd7 && wr_data[0];
    if (!rst_n) begin
      foreach (s_h[i]) begin s_h[i] = 0; s_v[i] = 0; a_h[i] = 0; a_v[i] = 0; end
      foreach (c_inv[i]) c_inv[i] = 0;
      s_fb = 0; a_fb = 0; c_en = 0; irqen = 0; run = 0; req = 0; stat = 0;
      hc = 0; vc = 0;
      return;
    end
    if (soft_rst) begin
      run = 0; req = 0; stat = 0; hc = 0; vc = 0; a_fb = 0;
      foreach (a_h[i]) begin a_h[i] = 0; a_v[i] = 0; end
    end else begin
      ld = st || (fe && req != 0);
      if (run == 0) begin hc = 0; vc = 0; end
      else if (hl) begin hc = 0; vc = vl ? 0 : vc + 1; end
      else hc++;
      if (st) run = 1;
      else if (fe && c_en == 0) run = 0;
      if (wctl && wr_data[1]) req = 1;
      else if (st || fe) req = 0;
      if (vbev) stat = 1;
      else if (wclr) stat = 0;
      if (ld) begin a_h = s_h; a_v = s_v; a_fb = s_fb; end
    end
    if (wr_en) begin
      case (wr_addr)
        3'd0: begin c_en = wr_data[0]; foreach (c_inv[i]) c_inv[i] = wr_data[2+i]; end
        3'd1: begin s_h[2] = wr_data[11:0]; s_h[1] = wr_data[27:16]; end
        3'd2: begin s_h[3] = wr_data[11:0]; s_h[0] = wr_data[27:16]; end
        3'd3: begin s_v[2] = wr_data[11:0]; s_v[1] = wr_data[27:16]; end
        3'd4: begin s_v[3] = wr_data[11:0]; s_v[0] = wr_data[27:16]; end
        3'd5: s_fb = wr_data;
        3'd6: irqen = wr_data[0];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    int ha, va, ex_x, ex_y;
    bit hr, vr, hin, vin, der;
    ha  = a_h[0] + a_h[1];
    va  = a_v[0] + a_v[1];
    hr  = run != 0 && hc < a_h[0];
    vr  = run != 0 && vc < a_v[0];
    hin = hc >= ha && hc < ha + a_h[2];
    vin = vc >= va && vc < va + a_v[2];
    der = run != 0 && hin && vin;
    ex_x = der ? hc - ha : 0;
    ex_y = der ? vc - va : 0;
    check("R1 hsync", hsync, hr ^ c_inv[0]);
    check("R2 vsync", vsync, vr ^ c_inv[1]);
    check("R3 de", de, der ^ c_inv[2]);
    check("R3 pix_x", int'(pix_x), ex_x);
    check("R3 pix_y", int'(pix_y), ex_y);
    check("R4 drive_on_fall", drive_on_fall, c_inv[3]);
    check("R7 en_status", en_status, run);
    check("R8 vblank_flag", vblank_flag, stat);
    check("R8 vblank_irq", vblank_irq, stat != 0 && irqen != 0);
    check("R5 fb_addr", int'(fb_addr), a_fb);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    tick();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_timing(int hsw, int hbp, int hact, int hfp,
                            int vsw, int vbp, int vact, int vfp);
    wr(1, (hbp << 16) | hact);
    wr(2, (hsw << 16) | hfp);
    wr(3, (vbp << 16) | vact);
    wr(4, (vsw << 16) | vfp);
  endtask

  initial begin
    run_n(3);
    check("R9 reset en_status", en_status, 0);
    rst_n = 1'b1;
    tick();
    // R10: first frame from staged values, 15 x 9 = 135 clocks
    set_timing(2, 3, 8, 2, 1, 2, 4, 2);
    wr(5, 32'h1000);
    wr(6, 1);
    wr(0, 1);
    tick();
    check("R10 fb loaded at start", int'(fb_addr), 32'h1000);
    run_n(200);
    wr(7, 1);            // R8 clear by writing 1
    check("R8 flag cleared", vblank_flag, 0);
    run_n(100);
    // R5: staged changes wait for a load request
    set_timing(3, 2, 5, 3, 2, 1, 3, 1);
    wr(5, 32'h2000);
    run_n(150);
    check("R5 fb held without request", int'(fb_addr), 32'h1000);
    // request load and change polarity (R4)
    wr(0, 1 | 2 | 4 | 16 | 32);
    run_n(400);
    check("R5 fb after boundary", int'(fb_addr), 32'h2000);
    // R6: request was consumed; new staged value must wait
    wr(5, 32'h3000);
    wr(6, 0);
    run_n(300);
    check("R6 no second load", int'(fb_addr), 32'h2000);
    // R7: stop completes at frame end
    wr(0, 8);
    check("R7 still running after clear", en_status, 1);
    run_n(150);
    check("R7 stopped after frame", en_status, 0);
    run_n(20);
    // R10: restart loads staged directly
    wr(0, 1);
    tick();
    check("R10 fb on restart", int'(fb_addr), 32'h3000);
    run_n(60);
    // R9: soft reset during a frame
    soft_rst = 1'b1;
    run_n(5);
    check("R9 soft en_status", en_status, 0);
    check("R9 soft fb", int'(fb_addr), 0);
    soft_rst = 1'b0;
    run_n(250);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule